// File: doc/BRIEF.md
# Exclusive Reservation Tracker

This block keeps one reservation for load-exclusive / store-exclusive pairs. It sits beside the load/store path, after address translation. Each cycle it may be handed one memory request. The request carries the instruction word, the virtual address, the translated physical address and the value of the instruction's base register. The caller reads that base value from the register named by instruction bits [19:16]. A load-exclusive opens a reservation on the request's key. A later store-exclusive to the same key succeeds once and closes the reservation.

The block checks every store-exclusive against the reservation. A failing one has its memory write gated off in the same cycle. One cycle later the block reports a status word: 0 for success, 1 for failure. The status goes to the register named by instruction bits [15:12]. Ordinary loads and stores pass through without changing the reservation.

The request side is valid/ready. `req_ready` is held high, so a request is taken in every cycle that `req_valid` is high and there is never back-pressure. The status side is a plain one-cycle strobe with no ready: the register file must take it in the cycle it appears.

Top module: `excl_monitor`

## Requirements
- R1: After reset the reservation is disarmed and its tag is all ones. A store-exclusive whose key is 0xFFFFFFFF therefore fails.
- R2: A request is a load-exclusive when `req_is_load` is 1 and (instr & 0x0FF000F0) is 0x01900090 or 0x01D00090. It is a store-exclusive when `req_is_load` is 0 and the masked word is 0x01800090 or 0x01C00090.
- R3: A load-exclusive arms the reservation with its key only when `req_base` equals `req_vaddr`. Otherwise the reservation is left unchanged.
- R4: A store-exclusive succeeds when the reservation is armed and its tag equals the store's key. `mem_wr_en` is then high in the same cycle, and one cycle later the block reports status 0 (`sts_fail`=0).
- R5: A successful store-exclusive disarms the reservation and sets the tag back to all ones.
- R6: A failing store-exclusive holds `mem_wr_en` low and reports status 1 one cycle later. The reservation is left unchanged.
- R7: `sts_valid` is high for exactly the cycle after each accepted store-exclusive and at no other time. `sts_reg` then carries instr[15:12] of that store.
- R8: The key is `req_paddr` OR'd with `req_vaddr[1:0]` in bits [1:0]. Accesses whose keys differ only in those bits do not match.
- R9: Ordinary loads and stores do not change the reservation and produce no status. `mem_wr_en` equals `req_valid` for an ordinary store and is 0 for any load.
- R10: A new arming load-exclusive replaces the previous tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (held high) |
| req_is_load | input | 1 | 1 for a load, 0 for a store |
| req_instr | input | 32 | Instruction word of the access |
| req_vaddr | input | 32 | Virtual address |
| req_paddr | input | 32 | Translated physical address |
| req_base | input | 32 | Value of the base register (instr[19:16]) |
| mem_wr_en | output | 1 | Combinational write gate for this request |
| sts_valid | output | 1 | Status strobe, one cycle after a store-exclusive |
| sts_reg | output | 4 | Destination register index for the status |
| sts_fail | output | 1 | Status value: 0 for success, 1 for failure |

## Verification
`mem_wr_en` is combinational, so the bench samples it 1 ns after driving a request at the falling edge, in the same cycle as the request. The status triple and the reservation update take effect at the next rising edge. The bench therefore checks `sts_valid`, `sts_reg` and `sts_fail` at the following falling edge, just before it drives the next request. In cycles after anything other than a store-exclusive it checks that `sts_valid` is 0. A reference model inside the bench tracks the tag and the armed flag and advances once per request, in step with the design's register update.

// File: rtl/excl_pkg.sv
package excl_pkg;
  localparam logic [31:0] OPC_MASK   = 32'h0FF0_00F0;
  localparam logic [31:0] LDX_WORD_A = 32'h0190_0090;
  localparam logic [31:0] LDX_PAIR_B = 32'h01D0_0090;
  localparam logic [31:0] STX_WORD_A = 32'h0180_0090;
  localparam logic [31:0] STX_PAIR_B = 32'h01C0_0090;
  localparam int RD_LSB = 12;

  typedef enum logic [1:0] {
    ACC_PLAIN = 2'd0,
    ACC_LDX   = 2'd1,
    ACC_STX   = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/excl_decode.sv
module excl_decode
  import excl_pkg::*;
#(
  parameter int IW = 32,
  parameter int RW = 4
) (
  input  logic          valid,
  input  logic          is_load,
  input  logic [IW-1:0] instr,
  output acc_kind_e     kind,
  output logic [RW-1:0] rd_idx
);
  logic [31:0] masked;
  logic        ldx_pat;
  logic        stx_pat;
  logic        unused_fields;

  assign masked  = instr[31:0] & OPC_MASK;
  assign ldx_pat = (masked == LDX_WORD_A) || (masked == LDX_PAIR_B);
  assign stx_pat = (masked == STX_WORD_A) || (masked == STX_PAIR_B);
  assign rd_idx  = instr[RD_LSB +: RW];
  assign unused_fields = ^{instr[31:28], instr[19:16], instr[11:8], instr[3:0]};

  always_comb begin
    kind = ACC_PLAIN;
    if (valid && is_load && ldx_pat)
      kind = ACC_LDX;
    else if (valid && !is_load && stx_pat)
      kind = ACC_STX;
  end
endmodule

// File: rtl/excl_resv.sv
module excl_resv #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          release_i,
  input  logic [AW-1:0] key,
  output logic          hit
);
  localparam logic [AW-1:0] IDLE_TAG = '1;

  logic [AW-1:0] tag_q;
  logic          armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q   <= IDLE_TAG;
      armed_q <= 1'b0;
    end else if (arm) begin
      tag_q   <= key;
      armed_q <= 1'b1;
    end else if (release_i) begin
      tag_q   <= IDLE_TAG;
      armed_q <= 1'b0;
    end
  end

  assign hit = armed_q && (tag_q == key);

  a_r5_release_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    release_i && !arm |=> !armed_q && (tag_q == IDLE_TAG));
  a_r10_arm_loads_key: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> armed_q && (tag_q == $past(key)));
  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !arm && !release_i |=> $stable(tag_q) && $stable(armed_q));
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 32,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_is_load,
  input  logic [IW-1:0] req_instr,
  input  logic [AW-1:0] req_vaddr,
  input  logic [AW-1:0] req_paddr,
  input  logic [AW-1:0] req_base,
  output logic          mem_wr_en,
  output logic          sts_valid,
  output logic [RW-1:0] sts_reg,
  output logic          sts_fail
);
  localparam int LOWB = 2;

  acc_kind_e     kind;
  logic [RW-1:0] rd_idx;
  logic [AW-1:0] key;
  logic          hit;
  logic          arm;
  logic          release_w;
  logic          stx;

  assign req_ready = 1'b1;
  assign key = req_paddr | {{(AW-LOWB){1'b0}}, req_vaddr[LOWB-1:0]};

  excl_decode #(.IW(IW), .RW(RW)) u_dec (
    .valid   (req_valid),
    .is_load (req_is_load),
    .instr   (req_instr),
    .kind    (kind),
    .rd_idx  (rd_idx)
  );

  assign stx       = (kind == ACC_STX);
  assign arm       = (kind == ACC_LDX) && (req_base == req_vaddr);
  assign release_w = stx && hit;

  excl_resv #(.AW(AW)) u_resv (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .release_i (release_w),
    .key       (key),
    .hit       (hit)
  );

  assign mem_wr_en = req_valid && !req_is_load && (!stx || hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_valid <= 1'b0;
      sts_reg   <= '0;
      sts_fail  <= 1'b0;
    end else begin
      sts_valid <= stx;
      if (stx) begin
        sts_reg  <= rd_idx;
        sts_fail <= !hit;
      end
    end
  end

  a_r4_success_wrote: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid && !sts_fail |-> $past(mem_wr_en));
  a_r6_fail_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid && sts_fail |-> !$past(mem_wr_en));
  a_r7_status_from_store: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |-> $past(req_valid && !req_is_load));
  a_r9_no_write_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    req_is_load |-> !mem_wr_en);
endmodule

// File: tb/excl_monitor_tb.sv
module excl_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_is_load = 1'b0;
  logic [31:0] req_instr = '0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_paddr = '0;
  logic [31:0] req_base = '0;
  logic        mem_wr_en;
  logic        sts_valid;
  logic [3:0]  sts_reg;
  logic        sts_fail;

  int n_vec = 0;
  int n_bad = 0;

  logic [31:0] m_tag = 32'hFFFF_FFFF;
  logic        m_armed = 1'b0;
  logic        p_sv = 1'b0;
  logic [3:0]  p_reg = '0;
  logic        p_fail = 1'b0;
  string       p_tag = "R7";

  always #10 clk = ~clk;

  excl_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_load(req_is_load), .req_instr(req_instr), .req_vaddr(req_vaddr),
    .req_paddr(req_paddr), .req_base(req_base), .mem_wr_en(mem_wr_en),
    .sts_valid(sts_valid), .sts_reg(sts_reg), .sts_fail(sts_fail)
  );

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] mk(int kind, logic [3:0] rd, logic [3:0] rn, bit alt);
    logic [31:0] w;
    case (kind)
      1: w = alt ? 32'h01D0_0090 : 32'h0190_0090;
      2: w = alt ? 32'h01C0_0090 : 32'h0180_0090;
      default: w = alt ? 32'h0590_0000 : 32'h0080_0090;
    endcase
    w = w | 32'hE000_0000 | {12'h0, rn, rd, 12'h0} | {20'h0, 4'h5, 4'h0, 4'h3};
    return w;
  endfunction

  function automatic bit is_ldx(logic [31:0] w);
    return ((w & 32'h0FF0_00F0) == 32'h0190_0090) || ((w & 32'h0FF0_00F0) == 32'h01D0_0090);
  endfunction
  function automatic bit is_stx(logic [31:0] w);
    return ((w & 32'h0FF0_00F0) == 32'h0180_0090) || ((w & 32'h0FF0_00F0) == 32'h01C0_0090);
  endfunction

  task automatic check_status();
    chk(p_tag, "sts_valid", {31'b0, sts_valid}, {31'b0, p_sv});
    if (p_sv) begin
      chk("R7", "sts_reg", {28'b0, sts_reg}, {28'b0, p_reg});
      chk(p_tag, "sts_fail", {31'b0, sts_fail}, {31'b0, p_fail});
    end
  endtask

  task automatic step(bit v, bit ld, logic [31:0] ins, logic [31:0] va,
                      logic [31:0] pa, logic [31:0] base, string tag);
    bit ldx, stx, ok, exp_wr;
    logic [31:0] key;
    @(negedge clk);
    check_status();
    req_valid = v; req_is_load = ld; req_instr = ins;
    req_vaddr = va; req_paddr = pa; req_base = base;
    #1;
    key = pa | {30'b0, va[1:0]};
    ldx = v && ld && is_ldx(ins);
    stx = v && !ld && is_stx(ins);
    ok  = m_armed && (m_tag == key);
    exp_wr = v && !ld && (!stx || ok);
    chk(tag, "mem_wr_en", {31'b0, mem_wr_en}, {31'b0, exp_wr});
    chk("R9", "req_ready", {31'b0, req_ready}, 32'd1);
    p_sv = stx; p_reg = ins[15:12]; p_fail = !ok; p_tag = tag;
    if (ldx && base == va) begin
      m_tag = key; m_armed = 1'b1;
    end else if (stx && ok) begin
      m_tag = 32'hFFFF_FFFF; m_armed = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] pool [4];
    void'($urandom(32'd1234));
    pool[0] = 32'h1000_0000; pool[1] = 32'h1000_0004;
    pool[2] = 32'h2000_0100; pool[3] = 32'hFFFF_FFFC;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "sts_valid after reset", {31'b0, sts_valid}, 32'd0);
    chk("R1", "mem_wr_en idle", {31'b0, mem_wr_en}, 32'd0);
    rst_n = 1'b1;
    // R1: store-exclusive to key all ones right after reset fails
    step(1, 0, mk(2, 4'h3, 4'h1, 0), 32'h0000_0003, 32'hFFFF_FFFC, 32'h0, "R1");
    // R2/R4/R5: arm then succeed, then second store fails
    step(1, 1, mk(1, 4'h2, 4'h1, 1), 32'h4000_0010, 32'h1000_0000, 32'h4000_0010, "R2");
    step(1, 0, mk(2, 4'hA, 4'h1, 1), 32'h4000_0010, 32'h1000_0000, 32'h0, "R4");
    step(1, 0, mk(2, 4'h5, 4'h1, 0), 32'h4000_0010, 32'h1000_0000, 32'h0, "R5");
    // R3: base differs from va, no arming
    step(1, 1, mk(1, 4'h2, 4'h1, 0), 32'h4000_0010, 32'h1000_0000, 32'h4000_0014, "R3");
    step(1, 0, mk(2, 4'h6, 4'h1, 0), 32'h4000_0010, 32'h1000_0000, 32'h0, "R3");
    // R8: keys differ only in low bits
    step(1, 1, mk(1, 4'h2, 4'h1, 0), 32'h4000_0011, 32'h1000_0000, 32'h4000_0011, "R8");
    step(1, 0, mk(2, 4'h7, 4'h1, 0), 32'h4000_0012, 32'h1000_0000, 32'h0, "R8");
    // R6: failure kept the reservation; matching store then succeeds
    step(1, 0, mk(2, 4'h8, 4'h1, 0), 32'h4000_0011, 32'h1000_0000, 32'h0, "R6");
    // R10: second arm replaces tag
    step(1, 1, mk(1, 4'h0, 4'h1, 0), 32'h10, 32'h1000_0000, 32'h10, "R10");
    step(1, 1, mk(1, 4'h0, 4'h1, 0), 32'h20, 32'h2000_0100, 32'h20, "R10");
    // R9: plain store and load between do not disturb
    step(1, 0, mk(0, 4'h1, 4'h1, 0), 32'h20, 32'h2000_0100, 32'h0, "R9");
    step(1, 1, mk(0, 4'h1, 4'h1, 1), 32'h20, 32'h2000_0100, 32'h20, "R9");
    step(1, 0, mk(2, 4'h9, 4'h1, 0), 32'h10, 32'h1000_0000, 32'h0, "R10");
    step(1, 0, mk(2, 4'hF, 4'h1, 1), 32'h20, 32'h2000_0100, 32'h0, "R10");
    // R2: decode depends on direction (store-exclusive pattern with load flag)
    step(1, 1, mk(2, 4'h4, 4'h1, 0), 32'h30, 32'h1000_0004, 32'h30, "R2");
    step(0, 0, mk(2, 4'h4, 4'h1, 0), 32'h30, 32'h1000_0004, 32'h0, "R9");
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [31:0] va, pa, base;
      string t;
      k = $urandom_range(0, 9);
      pa = pool[$urandom_range(0, 3)];
      va = {$urandom_range(0, 3) == 0 ? 30'h1 : 30'h2, 2'($urandom_range(0, 3))};
      base = ($urandom_range(0, 3) != 0) ? va : va ^ 32'h4;
      if (k < 3) begin
        t = "R2";
        step(1, 1, mk(1, 4'($urandom), 4'($urandom), 1'($urandom)), va, pa, base, t);
      end else if (k < 7) begin
        t = "R4";
        step(1, 0, mk(2, 4'($urandom), 4'($urandom), 1'($urandom)), va, pa, base, t);
      end else if (k < 9) begin
        t = "R9";
        step($urandom_range(0, 4) != 0, 1'($urandom), mk(0, 4'($urandom), 4'($urandom), 1'($urandom)),
             va, pa, base, t);
      end else begin
        t = "R9";
        step(0, 1'($urandom), $urandom, va, pa, base, t);
      end
    end
    step(0, 0, 32'h0, 32'h0, 32'h0, 32'h0, "R7");
    @(negedge clk);
    check_status();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule